// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides an input clock by a programmable ratio using the dual-modulus scheme found in frequency synthesizers. A prescaler stage divides the input clock by either 32 or 33, as a modulus-control signal selects. A main counter and a swallow counter both count the prescaler's output ticks. The swallow counter holds the prescaler at 33 for the first S ticks of each cycle. The main counter ends the cycle after M ticks. One full output period therefore spans 32·M + S input clocks. The analog prescaler is modelled here as a clock-enable divider running on the input clock.

An 18-bit divide word sets the ratio. Its upper 13 bits form M and its lower 5 bits form S, so the word read as one unsigned number equals the ratio for any legal setting. The block samples the word only at the edge that ends a divide cycle. Each output period is therefore built from a single consistent setting. At the end of every complete cycle the block emits a one-clock pulse for a downstream phase comparator.

Top module: `pss_divider`

## Requirements
- R1: For a word with M = div_word_i[17:5] and S = div_word_i[4:0], where 1 ≤ M and S ≤ M, consecutive output pulses are exactly 32·M + S input clock edges apart.
- R2: For a legal setting, the spacing between pulses equals the value of div_word_i read as an unsigned binary number, with bit 17 the most significant.
- R3: pulse_o is high for exactly one clock cycle per divide cycle.
- R4: Within each divide cycle, mod33_o is high for the first 33·S input clocks and low for the remaining 32·(M−S). It only goes high in the cycle where pulse_o is high.
- R5: A new word applies only from the divide cycle that starts after the next pulse. The period in progress keeps the old ratio.
- R6: If S > M, the swallow count is limited to M, which gives a ratio of 33·M.
- R7: If M = 0, the main count is taken as 1, which gives a ratio of 32 + min(S,1).
- R8: While reset is held, pulse_o and mod33_o are low. The first pulse appears on the 32nd rising edge after reset is released. The word sampled on that edge sets the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided (prescaler input) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_word_i | input | 18 | Divide word: bits 17:5 main count M, bits 4:0 swallow count S |
| pulse_o | output | 1 | One-clock pulse at the end of each divide cycle |
| mod33_o | output | 1 | Modulus control: high selects divide-by-33 in the prescaler |

## Verification
pulse_o is registered. It rises on the same edge that reloads the counters and samples the divide word. The interval that begins with a pulse therefore uses the word present just before that pulse, and the interval is complete at the next pulse. The bench samples outputs on the falling edge and measures each interval as the count of falling edges between pulses. After changing the word, it waits for two pulses before checking the new ratio. To check R5, it waits for one pulse and expects the old ratio. The first pulse after reset is expected on the 32nd edge. The mod33_o high count is accumulated over the same window as the interval and compared with 33·S at the closing pulse.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int unsigned PSS_MAIN_W = 13;
  localparam int unsigned PSS_SWAL_W = 5;

  // Main count actually used: a zero main count would never terminate.
  function automatic int unsigned eff_main(input int unsigned m);
    return (m == 0) ? 1 : m;
  endfunction

  // Swallow count actually used: cannot exceed the main count.
  function automatic int unsigned eff_swal(input int unsigned s, input int unsigned m_eff);
    return (s > m_eff) ? m_eff : s;
  endfunction

  // Input clocks per output period for a raw (M,S) setting.
  function automatic int unsigned div_ratio(input int unsigned m, input int unsigned s,
                                            input int unsigned swal_w);
    int unsigned me;
    me = eff_main(m);
    return (me << swal_w) + eff_swal(s, me);
  endfunction

  // Input clocks per period spent in the divide-by-(P+1) mode.
  function automatic int unsigned hi_clocks(input int unsigned m, input int unsigned s,
                                            input int unsigned swal_w);
    return ((1 << swal_w) + 1) * eff_swal(s, eff_main(m));
  endfunction

endpackage

// File: rtl/pss_prescale.sv
module pss_prescale #(
  parameter int unsigned SWAL_W = pss_pkg::PSS_SWAL_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mod_hi_i,
  output logic tick_o
);

  localparam int unsigned CW   = SWAL_W + 1;
  localparam int unsigned BASE = 1 << SWAL_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_w;

  // Last count value: BASE-1 for divide-by-BASE, BASE for divide-by-(BASE+1)
  assign last_w = mod_hi_i ? CW'(BASE) : CW'(BASE - 1);
  assign tick_o = (cnt_q == last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/pss_count.sv
module pss_count #(
  parameter int unsigned MAIN_W = pss_pkg::PSS_MAIN_W,
  parameter int unsigned SWAL_W = pss_pkg::PSS_SWAL_W,
  localparam int unsigned WORD_W = MAIN_W + SWAL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              mod_hi_o,
  output logic              wrap_o,
  output logic              pulse_o
);

  logic [MAIN_W-1:0] main_q;
  logic [SWAL_W-1:0] swal_q;
  logic              pulse_q;
  logic [MAIN_W-1:0] main_raw, main_ld;
  logic [SWAL_W-1:0] swal_raw, swal_ld;

  assign main_raw = word_i[WORD_W-1 -: MAIN_W];
  assign swal_raw = word_i[SWAL_W-1:0];
  assign main_ld  = MAIN_W'(pss_pkg::eff_main(int'(main_raw)));
  assign swal_ld  = SWAL_W'(pss_pkg::eff_swal(int'(swal_raw), int'(main_ld)));

  // Last prescaler period of the divide cycle is ending
  assign wrap_o   = tick_i && (main_q == MAIN_W'(1));
  assign mod_hi_o = (swal_q != '0);
  assign pulse_o  = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q  <= MAIN_W'(1);
      swal_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap_o;
      if (wrap_o) begin
        main_q <= main_ld;
        swal_q <= swal_ld;
      end else if (tick_i) begin
        main_q <= main_q - MAIN_W'(1);
        if (swal_q != '0) swal_q <= swal_q - SWAL_W'(1);
      end
    end
  end

endmodule

// File: rtl/pss_divider.sv
module pss_divider #(
  parameter int unsigned MAIN_W = pss_pkg::PSS_MAIN_W,
  parameter int unsigned SWAL_W = pss_pkg::PSS_SWAL_W,
  localparam int unsigned WORD_W = MAIN_W + SWAL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] div_word_i,
  output logic              pulse_o,
  output logic              mod33_o
);

  logic tick_w;   // prescaler output tick
  logic wrap_w;   // terminal count of the divide cycle
  logic mod_w;    // modulus control into the prescaler

  pss_prescale #(.SWAL_W(SWAL_W)) pre_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mod_hi_i (mod_w),
    .tick_o   (tick_w)
  );

  pss_count #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) cnt_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_w),
    .word_i   (div_word_i),
    .mod_hi_o (mod_w),
    .wrap_o   (wrap_w),
    .pulse_o  (pulse_o)
  );

  assign mod33_o = mod_w;

endmodule

// File: rtl/pss_divider_chk.sv
module pss_divider_chk #(
  parameter int unsigned MAIN_W = pss_pkg::PSS_MAIN_W,
  parameter int unsigned SWAL_W = pss_pkg::PSS_SWAL_W,
  localparam int unsigned WORD_W = MAIN_W + SWAL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] div_word_i,
  input logic              pulse_o,
  input logic              mod33_o,
  input logic              tick_i
);

  localparam int unsigned BASE = 1 << SWAL_W;

  logic [WORD_W-1:0] word_d;
  logic [31:0]       since, hi_acc, exp_ratio, exp_hi, gap;
  logic              seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_d <= '0; since <= '0; hi_acc <= '0;
      exp_ratio <= '0; exp_hi <= '0; gap <= '0; seen <= 1'b0;
    end else begin
      word_d <= div_word_i;
      since  <= pulse_o ? 32'd1 : since + 32'd1;
      hi_acc <= pulse_o ? 32'(mod33_o) : hi_acc + 32'(mod33_o);
      gap    <= tick_i ? 32'd0 : gap + 32'd1;
      if (pulse_o) begin
        seen      <= 1'b1;
        exp_ratio <= pss_pkg::div_ratio(int'(word_d[WORD_W-1 -: MAIN_W]),
                                        int'(word_d[SWAL_W-1:0]), SWAL_W);
        exp_hi    <= pss_pkg::hi_clocks(int'(word_d[WORD_W-1 -: MAIN_W]),
                                        int'(word_d[SWAL_W-1:0]), SWAL_W);
      end
    end
  end

  assert_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && seen) |-> (since == exp_ratio));

  assert_first_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !seen) |-> (since == BASE));

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  assert_hi_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && seen) |-> (hi_acc == exp_hi));

  assert_hi_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod33_o) |-> pulse_o);

  assert_prescale_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> ((gap == BASE - 1) || (gap == BASE)));

endmodule

bind pss_divider pss_divider_chk #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_word_i (div_word_i),
  .pulse_o    (pulse_o),
  .mod33_o    (mod33_o),
  .tick_i     (tick_w)
);

// File: tb/pss_divider_tb_top.sv
module pss_divider_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] div_word_i = '0;
  logic        pulse_o, mod33_o;

  int checks = 0, fails = 0;
  int cyc = 0, last_t = 0, last_iv = 0, pulse_cnt = 0;
  int mc_acc = 0, mc_iv = 0, wide = 0;
  logic prev_pulse = 1'b0;

  always #5 clk_i = ~clk_i;

  pss_divider dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_word_i(div_word_i),
    .pulse_o(pulse_o), .mod33_o(mod33_o)
  );

  // Falling-edge monitor: interval length and high count of modulus control
  always @(negedge clk_i) begin
    cyc = cyc + 1;
    if (pulse_o) begin
      last_iv = cyc - last_t;
      last_t  = cyc;
      pulse_cnt = pulse_cnt + 1;
      mc_iv  = mc_acc;
      mc_acc = 0;
      if (prev_pulse) wide = wide + 1;
    end
    if (mod33_o) mc_acc = mc_acc + 1;
    prev_pulse = pulse_o;
  end

  function automatic int exp_n(input int m, input int s);
    int mm, ss;
    mm = (m < 1) ? 1 : m;
    ss = (s < mm) ? s : mm;
    return mm * 32 + ss;
  endfunction

  function automatic int exp_hi(input int m, input int s);
    int mm, ss;
    mm = (m < 1) ? 1 : m;
    ss = (s < mm) ? s : mm;
    return ss * 33;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulses(input int n);
    int tgt;
    tgt = pulse_cnt + n;
    while (pulse_cnt < tgt) @(posedge clk_i);
  endtask

  task automatic set_word(input int m, input int s);
    @(negedge clk_i);
    div_word_i = {13'(m), 5'(s)};
  endtask

  task automatic t_reset_r8();
    int t0;
    rst_ni = 1'b0;
    div_word_i = {13'd10, 5'd3};
    repeat (3) @(negedge clk_i);
    check("R8 pulse in reset", int'(pulse_o), 0);
    check("R8 mod33 in reset", int'(mod33_o), 0);
    @(negedge clk_i);
    #1 rst_ni = 1'b1;
    t0 = cyc;
    wait_pulses(1);
    check("R8 first pulse edge", last_t - t0, 32);
    wait_pulses(1);
    check("R8 word at first pulse", last_iv, exp_n(10, 3));
  endtask

  task automatic t_ratio_r1(input int m, input int s);
    set_word(m, s);
    wait_pulses(2);
    check("R1 ratio", last_iv, exp_n(m, s));
    check("R4 mod33 clocks", mc_iv, exp_hi(m, s));
    check("R3 pulse width", wide, 0);
  endtask

  task automatic t_binary_r2(input int n);
    @(negedge clk_i);
    div_word_i = 18'(n);
    wait_pulses(2);
    check("R2 word equals ratio", last_iv, n);
  endtask

  task automatic t_midchange_r5();
    set_word(40, 9);
    wait_pulses(2);
    repeat (10) @(negedge clk_i);
    div_word_i = {13'd70, 5'd21};
    wait_pulses(1);
    check("R5 old period kept", last_iv, exp_n(40, 9));
    wait_pulses(1);
    check("R5 new period", last_iv, exp_n(70, 21));
  endtask

  task automatic t_swallow_r6();
    set_word(3, 20);
    wait_pulses(2);
    check("R6 clamp ratio", last_iv, 99);
    check("R6 clamp mod33", mc_iv, 99);
  endtask

  task automatic t_mzero_r7();
    set_word(0, 7);
    wait_pulses(2);
    check("R7 M zero S7", last_iv, 33);
    set_word(0, 0);
    wait_pulses(2);
    check("R7 M zero S0", last_iv, 32);
    check("R7 mod33 none", mc_iv, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main_seq
    t_reset_r8();
    t_ratio_r1(100, 17);
    t_ratio_r1(5, 5);
    t_ratio_r1(12, 0);
    t_ratio_r1(1, 1);
    t_ratio_r1(31, 31);
    t_binary_r2(1000);
    t_binary_r2(2345);
    t_midchange_r5();
    t_swallow_r6();
    t_mzero_r7();
    check("R3 no wide pulse", wide, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule